// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer, 256, 512 or 1024 words deep, whose write side and read side each run on their own clock. The two clocks may be unrelated or may be driven from one source. Producers push words with an active-low write enable on the write clock. Consumers pull words into a registered output with an active-low read enable on the read clock.

Five active-low status flags report the fill state. Empty and almost-empty belong to the read clock. Full, almost-full and more-than-half-full belong to the write clock. The two threshold offsets live in registers. While the load strobe is low, the write port stores into them and the read port returns their contents instead of moving FIFO data. A small selector alternates between the two registers, starting with the low-water mark. The output driver is modelled as a data bus plus a drive-enable output.

Top module: `pflag_async_fifo`

## Requirements
- R1: While `rst_n` is low, and after it rises with no other activity: `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, `half_n`=1 and `rd_data`=0.
- R2: A rising `wr_clk` edge with `wr_en_n`=0, `load_n`=1 and `full_n`=1 stores `wr_data`. A write attempted while `full_n`=0 stores nothing.
- R3: A rising `rd_clk` edge with `rd_en_n`=0, `load_n`=1 and `empty_n`=1 moves the oldest word into `rd_data`. With `rd_en_n`=1, `rd_data` keeps its value. A read attempted while `empty_n`=0 changes neither `rd_data` nor the FIFO contents.
- R4: Words leave in the order they were written, with all 18 bits unchanged.
- R5: `empty_n` is driven from the read clock and `full_n` from the write clock, and each is 0 when asserted. After a write into an empty FIFO, `empty_n` rises on the second `rd_clk` edge after the write edge.
- R6: After reset, both threshold offsets equal DEPTH/8-1: 31, 63 or 127 for depths 256, 512 and 1024.
- R7: `aempty_n` is 0 exactly when the number of stored words is less than or equal to the low-water offset.
- R8: `afull_n` is 0 exactly when the number of free words (DEPTH minus stored) is less than or equal to the high-water offset.
- R9: `half_n` is 0 exactly when the number of stored words is greater than DEPTH/2.
- R10: A rising `wr_clk` edge with `load_n`=0 and `wr_en_n`=0 stores `wr_data[9:0]` into one offset register and stores nothing in the FIFO. The first such edge after reset targets the low-water offset, the next targets the high-water offset, and the target keeps alternating after that.
- R11: A rising `rd_clk` edge with `load_n`=0 and `rd_en_n`=0 places one offset register on `rd_data[9:0]`, with `rd_data[17:10]`=0, and removes nothing from the FIFO. The low-water offset comes first after reset, and the source alternates on each such edge.
- R12: `rd_drive` equals the inverse of `oe_n`, and `oe_n` has no effect on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Active-low write enable |
| load_n | input | 1 | Active-low strobe that redirects both ports to the offset registers |
| wr_data | input | 18 | Write data; bits 9:0 also carry offset values |
| full_n | output | 1 | Active-low full flag, write clock |
| afull_n | output | 1 | Active-low almost-full flag, write clock |
| half_n | output | 1 | Active-low more-than-half-full flag, write clock |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low output drive enable |
| rd_data | output | 18 | Registered read data or offset read-back |
| rd_drive | output | 1 | High when the output bus would be driven |
| empty_n | output | 1 | Active-low empty flag, read clock |
| aempty_n | output | 1 | Active-low almost-empty flag, read clock |

## Verification
The hardest states to reach from the ports are the threshold edges near full and the write that is dropped while full. Reaching them takes hundreds of ordered writes with no read in between, while the flags must be sampled only after the pointer crossing has settled. The stimulus walks the fill level one word at a time from empty to full and back down. It checks every flag at every level, first with the reset offsets and again after new offsets have been loaded. This covers each boundary of the low-water, half and high-water comparisons on both sides.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

   // Width of each threshold offset register and of its data-bus field.
   localparam int OFS_WIDTH = 10;

   // Which offset register the load selector currently targets.
   typedef enum logic {
      SEL_LOW_MARK  = 1'b0,
      SEL_HIGH_MARK = 1'b1
   } mark_sel_e;

   // Offset applied at reset: one eighth of the depth, minus one.
   function automatic int default_offset(input int depth);
      return (depth / 8) - 1;
   endfunction

endpackage

// File: rtl/pflag_sync.sv
module pflag_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pflag_ram.sv
module pflag_ram #(
   parameter int  DATA_W = 18,
   parameter int  DEPTH  = 256,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // The read side registers this word, so the array itself stays flop-free.
   assign rdata = mem[raddr];

endmodule

// File: rtl/pflag_wr_ctrl.sv
module pflag_wr_ctrl
   import pflag_fifo_pkg::*;
#(
   parameter int  DEPTH = 256,
   parameter int  OFS_W = 10,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_n,
   input  logic             load_n,
   input  logic [OFS_W-1:0] ofs_in,
   input  logic [PW-1:0]    rd_gray_s,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [PW-1:0]    wr_gray,
   output logic [OFS_W-1:0] ofs_ae,
   output logic [OFS_W-1:0] ofs_af,
   output logic             full_n,
   output logic             afull_n,
   output logic             half_n
);

   localparam logic [PW-1:0]    CAP     = PW'(DEPTH);
   localparam logic [PW-1:0]    HALF    = PW'(DEPTH / 2);
   localparam int               CW      = ((PW > OFS_W) ? PW : OFS_W) + 1;
   localparam logic [OFS_W-1:0] OFS_RST = OFS_W'(default_offset(DEPTH));

   logic [PW-1:0] wr_bin, wr_bin_nxt, rd_bin_s, fill, space;
   logic          is_full, wr_ok, ld_ok;
   mark_sel_e     ld_sel;

   // Gray to binary: each bit is the parity of itself and all bits above it.
   always_comb begin
      for (int i = 0; i < PW; i++) begin
         rd_bin_s[i] = ^(rd_gray_s >> i);
      end
   end

   assign fill       = wr_bin - rd_bin_s;
   assign space      = CAP - fill;
   assign is_full    = (fill == CAP);
   assign wr_ok      = !wr_en_n && load_n && !is_full;
   assign ld_ok      = !wr_en_n && !load_n;
   assign wr_bin_nxt = wr_bin + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else if (wr_ok) begin
         wr_bin  <= wr_bin_nxt;
         wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_ae <= OFS_RST;
         ofs_af <= OFS_RST;
         ld_sel <= SEL_LOW_MARK;
      end else if (ld_ok) begin
         if (ld_sel == SEL_LOW_MARK) begin
            ofs_ae <= ofs_in;
         end else begin
            ofs_af <= ofs_in;
         end
         ld_sel <= (ld_sel == SEL_LOW_MARK) ? SEL_HIGH_MARK : SEL_LOW_MARK;
      end
   end

   assign mem_we   = wr_ok;
   assign mem_addr = wr_bin[AW-1:0];
   assign full_n   = !is_full;
   assign afull_n  = !(CW'(space) <= CW'(ofs_af));
   assign half_n   = !(fill > HALF);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CAP); // R2
   AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && !wr_en_n && load_n) |=> $stable(wr_bin)); // R2
   AST_LOAD_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_n && !load_n) |=> (ld_sel != $past(ld_sel))); // R10
   AST_LOAD_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n) |=> $stable(wr_bin)); // R10
   AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !afull_n); // R8

endmodule

// File: rtl/pflag_rd_ctrl.sv
module pflag_rd_ctrl
   import pflag_fifo_pkg::*;
#(
   parameter int  DATA_W = 18,
   parameter int  DEPTH  = 256,
   parameter int  OFS_W  = 10,
   localparam int AW     = $clog2(DEPTH),
   localparam int PW     = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_n,
   input  logic              load_n,
   input  logic [PW-1:0]     wr_gray_s,
   input  logic [DATA_W-1:0] mem_word,
   input  logic [OFS_W-1:0]  ofs_ae,
   input  logic [OFS_W-1:0]  ofs_af,
   output logic [AW-1:0]     mem_addr,
   output logic [PW-1:0]     rd_gray,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              aempty_n
);

   localparam logic [PW-1:0] CAP = PW'(DEPTH);
   localparam int            CW  = ((PW > OFS_W) ? PW : OFS_W) + 1;

   logic [PW-1:0] rd_bin, rd_bin_nxt, wr_bin_s, fill;
   logic          is_empty, rd_ok, pk_ok;
   mark_sel_e     pk_sel;

   always_comb begin
      for (int i = 0; i < PW; i++) begin
         wr_bin_s[i] = ^(wr_gray_s >> i);
      end
   end

   assign fill       = wr_bin_s - rd_bin;
   assign is_empty   = (fill == '0);
   assign rd_ok      = !rd_en_n && load_n && !is_empty;
   assign pk_ok      = !rd_en_n && !load_n;
   assign rd_bin_nxt = rd_bin + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bin  <= '0;
         rd_gray <= '0;
      end else if (rd_ok) begin
         rd_bin  <= rd_bin_nxt;
         rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         pk_sel  <= SEL_LOW_MARK;
      end else if (rd_ok) begin
         rd_data <= mem_word;
      end else if (pk_ok) begin
         rd_data <= DATA_W'((pk_sel == SEL_LOW_MARK) ? ofs_ae : ofs_af);
         pk_sel  <= (pk_sel == SEL_LOW_MARK) ? SEL_HIGH_MARK : SEL_LOW_MARK;
      end
   end

   assign mem_addr = rd_bin[AW-1:0];
   assign empty_n  = !is_empty;
   assign aempty_n = !(CW'(fill) <= CW'(ofs_ae));

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CAP); // R3
   AST_EMPTY_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !rd_en_n && load_n) |=> $stable(rd_bin)); // R3
   AST_IDLE_HOLDS_Q: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_n |=> $stable(rd_data)); // R3
   AST_PEEK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en_n && !load_n) |=> (pk_sel != $past(pk_sel))); // R11
   AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n); // R7

endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo #(
   parameter int  DATA_W      = 18,
   parameter int  DEPTH       = 256,
   parameter int  OFS_W       = pflag_fifo_pkg::OFS_WIDTH,
   parameter int  SYNC_STAGES = 2,
   localparam int AW          = $clog2(DEPTH),
   localparam int PW          = AW + 1
) (
   input  logic              rst_n,
   input  logic              wr_clk,
   input  logic              wr_en_n,
   input  logic              load_n,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full_n,
   output logic              afull_n,
   output logic              half_n,
   input  logic              rd_clk,
   input  logic              rd_en_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive,
   output logic              empty_n,
   output logic              aempty_n
);

   // Elaboration-time parameter checks.
   if (!(DEPTH == 256 || DEPTH == 512 || DEPTH == 1024)) begin : g_bad_depth
      $error("pflag_async_fifo: DEPTH must be 256, 512 or 1024");
   end
   if (DATA_W < OFS_W) begin : g_bad_width
      $error("pflag_async_fifo: DATA_W must cover the offset field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pflag_async_fifo: at least two synchronizer stages required");
   end

   logic              mem_we;
   logic [AW-1:0]     waddr, raddr;
   logic [DATA_W-1:0] mem_word;
   logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
   logic [OFS_W-1:0]  ofs_ae, ofs_af;

   pflag_wr_ctrl #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_wr (
      .clk      (wr_clk),
      .rst_n    (rst_n),
      .wr_en_n  (wr_en_n),
      .load_n   (load_n),
      .ofs_in   (wr_data[OFS_W-1:0]),
      .rd_gray_s(rd_gray_s),
      .mem_we   (mem_we),
      .mem_addr (waddr),
      .wr_gray  (wr_gray),
      .ofs_ae   (ofs_ae),
      .ofs_af   (ofs_af),
      .full_n   (full_n),
      .afull_n  (afull_n),
      .half_n   (half_n)
   );

   pflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk  (rd_clk),
      .rst_n(rst_n),
      .d    (wr_gray),
      .q    (wr_gray_s)
   );

   pflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk  (wr_clk),
      .rst_n(rst_n),
      .d    (rd_gray),
      .q    (rd_gray_s)
   );

   pflag_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .wr_clk(wr_clk),
      .we    (mem_we),
      .waddr (waddr),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (mem_word)
   );

   pflag_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OFS_W(OFS_W)) u_rd (
      .clk      (rd_clk),
      .rst_n    (rst_n),
      .rd_en_n  (rd_en_n),
      .load_n   (load_n),
      .wr_gray_s(wr_gray_s),
      .mem_word (mem_word),
      .ofs_ae   (ofs_ae),
      .ofs_af   (ofs_af),
      .mem_addr (raddr),
      .rd_gray  (rd_gray),
      .rd_data  (rd_data),
      .empty_n  (empty_n),
      .aempty_n (aempty_n)
   );

   assign rd_drive = !oe_n; // R12

endmodule

// File: tb/pflag_async_fifo_tb_top.sv
`timescale 1ns/1ps
module pflag_async_fifo_tb_top;

   localparam int DEPTH = 256;
   localparam int DW    = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en_n = 1'b1, load_n = 1'b1, rd_en_n = 1'b1, oe_n = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          full_n, afull_n, half_n, empty_n, aempty_n, rd_drive;

   always #2.5 clk = ~clk;

   pflag_async_fifo #(.DEPTH(DEPTH)) dut_i (
      .rst_n(rst_n), .wr_clk(clk), .wr_en_n(wr_en_n), .load_n(load_n),
      .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n), .half_n(half_n),
      .rd_clk(clk), .rd_en_n(rd_en_n), .oe_n(oe_n), .rd_data(rd_data),
      .rd_drive(rd_drive), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   // Reference model
   logic [DW-1:0] q_mem [DEPTH];
   int            head, tail, cnt, m_ae, m_af, m_wsel, m_rsel;
   logic [DW-1:0] exp_q;
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;

   // Vector table: {op[1:0], data[17:0], expected q[17:0]}; op 0 write, 1 read, 2 idle
   localparam logic [37:0] VEC [12] = '{
      {2'd0, 18'h00011, 18'h00000},
      {2'd0, 18'h2ABCD, 18'h00000},
      {2'd1, 18'h00000, 18'h00011},
      {2'd0, 18'h3FFFF, 18'h00000},
      {2'd2, 18'h00000, 18'h00011},
      {2'd1, 18'h00000, 18'h2ABCD},
      {2'd1, 18'h00000, 18'h3FFFF},
      {2'd1, 18'h00000, 18'h3FFFF},
      {2'd0, 18'h15555, 18'h00000},
      {2'd0, 18'h0AAAA, 18'h00000},
      {2'd1, 18'h00000, 18'h15555},
      {2'd1, 18'h00000, 18'h0AAAA}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_flags(input string req);
      check(req, "empty_n",  32'(empty_n),  32'(cnt != 0));
      check(req, "full_n",   32'(full_n),   32'(cnt != DEPTH));
      check(req, "half_n",   32'(half_n),   32'(!(cnt > DEPTH / 2)));
      check(req, "aempty_n", 32'(aempty_n), 32'(!(cnt <= m_ae)));
      check(req, "afull_n",  32'(afull_n),  32'(!((DEPTH - cnt) <= m_af)));
   endtask

   task automatic model_reset();
      head = 0; tail = 0; cnt = 0;
      m_ae = DEPTH / 8 - 1; m_af = DEPTH / 8 - 1;
      m_wsel = 0; m_rsel = 0; exp_q = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; load_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic wr_word(input logic [DW-1:0] d);
      @(negedge clk);
      wr_data = d; load_n = 1'b1; wr_en_n = 1'b0;
      @(negedge clk);
      wr_en_n = 1'b1;
      if (cnt < DEPTH) begin
         q_mem[tail] = d; tail = (tail + 1) % DEPTH; cnt++;
      end
   endtask

   task automatic rd_word();
      @(negedge clk);
      load_n = 1'b1; rd_en_n = 1'b0;
      @(negedge clk);
      rd_en_n = 1'b1;
      if (cnt > 0) begin
         exp_q = q_mem[head]; head = (head + 1) % DEPTH; cnt--;
      end
   endtask

   task automatic ld_wr(input logic [9:0] v);
      @(negedge clk);
      wr_data = {8'hFF, v}; load_n = 1'b0; wr_en_n = 1'b0;
      @(negedge clk);
      wr_en_n = 1'b1; load_n = 1'b1;
      if (m_wsel == 0) m_ae = int'(v); else m_af = int'(v);
      m_wsel ^= 1;
   endtask

   task automatic ld_rd();
      @(negedge clk);
      load_n = 1'b0; rd_en_n = 1'b0;
      @(negedge clk);
      rd_en_n = 1'b1; load_n = 1'b1;
      exp_q = DW'((m_rsel == 0) ? m_ae : m_af);
      m_rsel ^= 1;
   endtask

   task automatic fill_and_drain(input string tag, input int seed);
      for (int k = 1; k <= DEPTH; k++) begin
         wr_word(DW'(k * 37 + seed));
         settle();
         check_flags({tag, " R2 R5 R7 R8 R9 fill"});
      end
      wr_word(18'h3C3C3);   // dropped: FIFO is full
      settle();
      check_flags({tag, " R2 write while full"});
      for (int k = 1; k <= DEPTH; k++) begin
         rd_word();
         check({tag, " R4"}, "drain data", 32'(rd_data), 32'(exp_q));
         settle();
         check_flags({tag, " R5 R7 R8 R9 drain"});
      end
      rd_word();            // empty: nothing left, extra word never stored
      check({tag, " R2 R3"}, "read past empty", 32'(rd_data), 32'(exp_q));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();
      // R1 reset state
      check_flags("R1");
      check("R1", "rd_data", 32'(rd_data), 32'h0);

      // R5 empty flag latency after a write
      wr_word(18'h00123);
      check("R5", "empty_n edge+0", 32'(empty_n), 32'h0);
      @(negedge clk);
      check("R5", "empty_n edge+1", 32'(empty_n), 32'h0);
      @(negedge clk);
      check("R5", "empty_n edge+2", 32'(empty_n), 32'h1);
      settle();
      rd_word();
      check("R3 R4", "first word", 32'(rd_data), 32'h123);
      settle();

      // Vector table walk
      for (int i = 0; i < 12; i++) begin
         case (VEC[i][37:36])
            2'd0: wr_word(VEC[i][35:18]);
            2'd1: rd_word();
            default: @(negedge clk);
         endcase
         settle();
         if (VEC[i][37:36] != 2'd0)
            check("R3 R4", $sformatf("vector %0d q", i), 32'(rd_data), 32'(VEC[i][17:0]));
         check_flags("R3 R5 R7 vector");
      end

      // Full sweep with default offsets
      fill_and_drain("R6", 5);

      // Offset load and read-back with one word resident
      wr_word(18'h0F0F0);
      settle();
      ld_wr(10'd5);
      ld_wr(10'd10);
      settle();
      check_flags("R10 load stores no word");
      ld_rd();
      check("R11", "peek low mark", 32'(rd_data), 32'(exp_q));
      ld_rd();
      check("R11", "peek high mark", 32'(rd_data), 32'(exp_q));
      settle();
      check_flags("R11 peek removes no word");
      rd_word();
      check("R10 R11", "resident word", 32'(rd_data), 32'h0F0F0);
      settle();
      check_flags("R10 after resident read");

      // Sweep with loaded offsets
      fill_and_drain("R7 R8", 11);

      // Reset restores offsets and selector order
      do_reset();
      ld_rd();
      check("R6 R11", "peek after reset 1", 32'(rd_data), 32'(DEPTH / 8 - 1));
      ld_rd();
      check("R6 R11", "peek after reset 2", 32'(rd_data), 32'(DEPTH / 8 - 1));
      ld_wr(10'd7);
      for (int k = 1; k <= 10; k++) begin
         wr_word(DW'(k));
         settle();
         check_flags("R10 first load after reset targets low mark");
      end

      // Output drive enable
      @(negedge clk); oe_n = 1'b1;
      @(negedge clk);
      check("R12", "rd_drive off", 32'(rd_drive), 32'h0);
      check("R12", "rd_data unaffected", 32'(rd_data), 32'(exp_q));
      oe_n = 1'b0;
      @(negedge clk);
      check("R12", "rd_drive on", 32'(rd_drive), 32'h1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule